// File: doc/BRIEF.md
# Switched Descriptor Ring Handshake Controller

This controller holds the status fields of a ring of buffer descriptors that a switching receiver fills and a transmitter drains. Each descriptor carries three fields: a ready flag that hands it to the transmitter, a partial flag that marks a packet still being written or left unfinished, and a channel code naming the receiver channel that opened it. Payload storage lives elsewhere. The block only moves the descriptors through their states.

The receiver side reports one operation per cycle: open, done, error or abort. Open claims the descriptor at the write pointer. The other three close it. An aborted packet leaves its descriptor stuck, still marked with the channel code. If a later open lands on a descriptor whose partial flag is set, the descriptor is left alone and a busy interrupt pulses. The transmitter asks for work with a request pulse. One cycle later it gets one of three answers: a descriptor to send, a skip of an errored one, or the release of a stuck one. A release comes only after a programmable number of attempts, and only while the timeout is enabled. An occupancy counter tracks completed packets that have not yet been sent. An inspection port lets the host read any descriptor.

Top module: `bd_switch_ring`

## Requirements
- R1: After synchronous reset every descriptor has ready=0, partial=0 and channel 0, occ_count is 0, and tx_valid, tx_skip, tx_free and irq_busy are low.
- R2: rx_op=1 (open) on a descriptor with ready=0 and partial=0 at the write pointer sets partial=1, keeps ready=0 and stores rx_chan as its channel code.
- R3: rx_op=2 (done) while a descriptor is open sets ready=1 and clears partial, advances the write pointer and raises occ_count by one.
- R4: rx_op=3 (error) while a descriptor is open sets ready=1 and keeps partial=1, advances the write pointer and leaves occ_count unchanged.
- R5: rx_op=4 (abort) while a descriptor is open keeps partial=1 and ready=0, keeps the channel code and advances the write pointer.
- R6: An open that finds partial=1 at the write pointer changes nothing and pulses irq_busy for one cycle in the next cycle. An open that finds ready=1 (ring full) is ignored without an interrupt.
- R7: tx_req on a descriptor with ready=1 and partial=0 gives tx_valid=1 with tx_idx equal to its index in the next cycle. The descriptor returns to all zeros, the read pointer advances and occ_count drops by one.
- R8: tx_req on a descriptor with ready=1 and partial=1 gives tx_skip=1 and no tx_valid. The descriptor returns to all zeros and the read pointer advances.
- R9: tx_req on a stuck descriptor with to_en=0, on a descriptor still being filled, or on a clean descriptor produces no outcome. It neither changes the descriptor nor counts an attempt.
- R10: With to_en=1, the to_limit-th request on a stuck descriptor gives tx_free=1 (a limit of 0 acts as 1). That descriptor is cleared, including its channel code, and the read pointer advances.
- R11: The attempt count restarts at zero whenever the read pointer advances.
- R12: A done and a send in the same cycle leave occ_count unchanged. The count stays between 0 and the ring depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_op | input | 3 | Receiver operation: 0 none, 1 open, 2 done, 3 error, 4 abort |
| rx_chan | input | CHAN_W | Channel code of the receiver issuing an open |
| tx_req | input | 1 | Transmitter fetch request |
| to_en | input | 1 | Enables releasing stuck descriptors |
| to_limit | input | RETRY_W | Attempts before a stuck descriptor is released |
| tx_valid | output | 1 | A descriptor was handed over for sending |
| tx_skip | output | 1 | An errored descriptor was skipped |
| tx_free | output | 1 | A stuck descriptor was released |
| tx_idx | output | IDX_W | Index the last request acted on |
| irq_busy | output | 1 | Busy interrupt pulse |
| occ_count | output | OCC_W | Completed packets waiting to be sent |
| insp_idx | input | IDX_W | Descriptor index for host inspection |
| insp_ready | output | 1 | Ready flag of the inspected descriptor |
| insp_partial | output | 1 | Partial flag of the inspected descriptor |
| insp_chan | output | CHAN_W | Channel code of the inspected descriptor |

## Verification
The busy interrupt is the hardest case to reach. It needs a stuck descriptor that the write pointer comes back to, so the bench aborts a packet, completes enough packets to wrap the write pointer around the ring while the disabled timeout holds the transmitter in place, and then opens again. The timeout sweep resets the ring before each limit from 0 to 4. For each limit it counts the requests until the release, then leaves a second stuck descriptor straight after the first to show that the attempt count restarted.

// File: rtl/bd_switch_pkg.sv
package bd_switch_pkg;

    typedef enum logic [2:0] {
        RX_NONE  = 3'd0,
        RX_OPEN  = 3'd1,
        RX_DONE  = 3'd2,
        RX_ERR   = 3'd3,
        RX_ABORT = 3'd4
    } rx_op_e;

    typedef struct packed {
        logic ready;
        logic partial;
    } bd_flags_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_SKIP,
        TX_FREE
    } tx_act_e;

    localparam bd_flags_t BD_CLEAN = '{ready: 1'b0, partial: 1'b0};

    function automatic logic [15:0] ring_step(input logic [15:0] idx, input int unsigned depth);
        return (idx == 16'(depth - 1)) ? 16'd0 : idx + 16'd1;
    endfunction

endpackage

// File: rtl/bd_desc_store.sv
module bd_desc_store
    import bd_switch_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CHAN_W = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_we,
    input  logic [IDX_W-1:0]  rx_idx,
    input  bd_flags_t         rx_flags,
    input  logic              rx_chan_we,
    input  logic [CHAN_W-1:0] rx_chan,
    input  logic              tx_clr,
    input  logic [IDX_W-1:0]  tx_idx,
    output bd_flags_t         wr_flags,
    output bd_flags_t         rd_flags,
    input  logic [IDX_W-1:0]  insp_idx,
    output bd_flags_t         insp_flags,
    output logic [CHAN_W-1:0] insp_chan
);
    bd_flags_t         flags_q [DEPTH];
    logic [CHAN_W-1:0] chan_q  [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                flags_q[i] <= BD_CLEAN;
                chan_q[i]  <= '0;
            end else begin
                if (tx_clr && tx_idx == IDX_W'(i)) begin
                    flags_q[i] <= BD_CLEAN;
                    chan_q[i]  <= '0;
                end
                if (rx_we && rx_idx == IDX_W'(i))
                    flags_q[i] <= rx_flags;
                if (rx_chan_we && rx_idx == IDX_W'(i))
                    chan_q[i] <= rx_chan;
            end
        end
    end

    assign wr_flags   = flags_q[rx_idx];
    assign rd_flags   = flags_q[tx_idx];
    assign insp_flags = flags_q[insp_idx];
    assign insp_chan  = chan_q[insp_idx];

    // receiver and transmitter never update the same descriptor in one cycle
    assert_no_shared_write_R7: assert property (@(posedge clk) disable iff (rst)
        !(tx_clr && rx_we && tx_idx == rx_idx));

endmodule

// File: rtl/bd_rx_ctrl.sv
module bd_rx_ctrl
    import bd_switch_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CHAN_W = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_op_e            rx_op,
    input  bd_flags_t         cur_flags,
    output logic [IDX_W-1:0]  wr_ptr,
    output logic              open_q,
    output logic              we,
    output bd_flags_t         wflags,
    output logic              chan_we,
    output logic              inc,
    output logic              irq_busy
);
    logic busy_now;
    logic advance;
    logic open_set;

    always_comb begin
        we       = 1'b0;
        wflags   = BD_CLEAN;
        chan_we  = 1'b0;
        inc      = 1'b0;
        busy_now = 1'b0;
        advance  = 1'b0;
        open_set = 1'b0;
        unique case (rx_op)
            RX_OPEN: begin
                if (cur_flags.partial) begin
                    busy_now = 1'b1;
                end else if (!cur_flags.ready && !open_q) begin
                    we       = 1'b1;
                    wflags   = '{ready: 1'b0, partial: 1'b1};
                    chan_we  = 1'b1;
                    open_set = 1'b1;
                end
            end
            RX_DONE: if (open_q) begin
                we      = 1'b1;
                wflags  = '{ready: 1'b1, partial: 1'b0};
                inc     = 1'b1;
                advance = 1'b1;
            end
            RX_ERR: if (open_q) begin
                we      = 1'b1;
                wflags  = '{ready: 1'b1, partial: 1'b1};
                advance = 1'b1;
            end
            RX_ABORT: if (open_q) begin
                we      = 1'b1;
                wflags  = '{ready: 1'b0, partial: 1'b1};
                advance = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            open_q   <= 1'b0;
            irq_busy <= 1'b0;
        end else begin
            irq_busy <= busy_now;
            if (open_set)
                open_q <= 1'b1;
            else if (advance)
                open_q <= 1'b0;
            if (advance)
                wr_ptr <= IDX_W'(ring_step(16'(wr_ptr), DEPTH));
        end
    end

    assert_busy_after_open_R6: assert property (@(posedge clk) disable iff (rst)
        irq_busy |-> $past(rx_op == RX_OPEN));

    assert_done_advances_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_op == RX_DONE && open_q) |=> (wr_ptr != $past(wr_ptr) && !open_q));

endmodule

// File: rtl/bd_tx_ctrl.sv
module bd_tx_ctrl
    import bd_switch_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int IDX_W   = 3,
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_req,
    input  logic               to_en,
    input  logic [RETRY_W-1:0] to_limit,
    input  bd_flags_t          cur_flags,
    input  logic               rx_open,
    input  logic [IDX_W-1:0]   wr_ptr,
    output logic [IDX_W-1:0]   tx_ptr,
    output logic               clr,
    output logic               dec,
    output logic               tx_valid,
    output logic               tx_skip,
    output logic               tx_free,
    output logic [IDX_W-1:0]   tx_idx
);
    logic [RETRY_W-1:0] attempts_q;
    logic [RETRY_W-1:0] eff_limit;
    logic               filling;
    logic               count_now;
    tx_act_e            act;

    assign filling   = rx_open && (wr_ptr == tx_ptr);
    assign eff_limit = (to_limit == '0) ? RETRY_W'(1) : to_limit;

    always_comb begin
        act       = TX_IDLE;
        count_now = 1'b0;
        if (tx_req) begin
            if (cur_flags.ready && !cur_flags.partial)
                act = TX_SEND;
            else if (cur_flags.ready && cur_flags.partial)
                act = TX_SKIP;
            else if (cur_flags.partial && !filling && to_en) begin
                if ({1'b0, attempts_q} + 1'b1 >= {1'b0, eff_limit})
                    act = TX_FREE;
                else
                    count_now = 1'b1;
            end
        end
    end

    assign clr = (act != TX_IDLE);
    assign dec = (act == TX_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ptr     <= '0;
            attempts_q <= '0;
            tx_valid   <= 1'b0;
            tx_skip    <= 1'b0;
            tx_free    <= 1'b0;
            tx_idx     <= '0;
        end else begin
            tx_valid <= (act == TX_SEND);
            tx_skip  <= (act == TX_SKIP);
            tx_free  <= (act == TX_FREE);
            tx_idx   <= tx_ptr;
            if (clr) begin
                tx_ptr     <= IDX_W'(ring_step(16'(tx_ptr), DEPTH));
                attempts_q <= '0;
            end else if (count_now) begin
                attempts_q <= attempts_q + 1'b1;
            end
        end
    end

    assert_single_outcome_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_valid, tx_skip, tx_free}));

    assert_free_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
        tx_free |-> $past(to_en && tx_req));

endmodule

// File: rtl/bd_occ_counter.sv
module bd_occ_counter #(
    parameter int MAXV  = 8,
    parameter int OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [OCC_W-1:0] count_q
);
    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (inc && !dec && count_q != OCC_W'(MAXV))
            count_q <= count_q + 1'b1;
        else if (dec && !inc && count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assert_occ_moves_on_event_R12: assert property (@(posedge clk) disable iff (rst)
        (count_q != $past(count_q)) |-> $past(inc != dec));

    assert_occ_step_R3: assert property (@(posedge clk) disable iff (rst)
        $past(inc && !dec && count_q != OCC_W'(MAXV)) |-> count_q == $past(count_q) + 1'b1);

endmodule

// File: rtl/bd_switch_ring.sv
module bd_switch_ring
    import bd_switch_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int CHAN_W  = 4,
    parameter int RETRY_W = 4,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         rx_op,
    input  logic [CHAN_W-1:0]  rx_chan,
    input  logic               tx_req,
    input  logic               to_en,
    input  logic [RETRY_W-1:0] to_limit,
    output logic               tx_valid,
    output logic               tx_skip,
    output logic               tx_free,
    output logic [IDX_W-1:0]   tx_idx,
    output logic               irq_busy,
    output logic [OCC_W-1:0]   occ_count,
    input  logic [IDX_W-1:0]   insp_idx,
    output logic               insp_ready,
    output logic               insp_partial,
    output logic [CHAN_W-1:0]  insp_chan
);
    rx_op_e           op;
    logic [IDX_W-1:0] wr_ptr, tx_ptr;
    logic             rx_open, rx_we, rx_chan_we, occ_inc;
    logic             tx_clr, occ_dec;
    bd_flags_t        rx_wflags, wr_flags, rd_flags, insp_flags;

    assign op = rx_op_e'(rx_op);

    bd_rx_ctrl #(.DEPTH(DEPTH), .CHAN_W(CHAN_W), .IDX_W(IDX_W)) u_rx (
        .clk(clk), .rst(rst), .rx_op(op), .cur_flags(wr_flags),
        .wr_ptr(wr_ptr), .open_q(rx_open), .we(rx_we), .wflags(rx_wflags),
        .chan_we(rx_chan_we), .inc(occ_inc), .irq_busy(irq_busy));

    bd_tx_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RETRY_W(RETRY_W)) u_tx (
        .clk(clk), .rst(rst), .tx_req(tx_req), .to_en(to_en), .to_limit(to_limit),
        .cur_flags(rd_flags), .rx_open(rx_open), .wr_ptr(wr_ptr), .tx_ptr(tx_ptr),
        .clr(tx_clr), .dec(occ_dec), .tx_valid(tx_valid), .tx_skip(tx_skip),
        .tx_free(tx_free), .tx_idx(tx_idx));

    bd_desc_store #(.DEPTH(DEPTH), .CHAN_W(CHAN_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst), .rx_we(rx_we), .rx_idx(wr_ptr), .rx_flags(rx_wflags),
        .rx_chan_we(rx_chan_we), .rx_chan(rx_chan), .tx_clr(tx_clr), .tx_idx(tx_ptr),
        .wr_flags(wr_flags), .rd_flags(rd_flags), .insp_idx(insp_idx),
        .insp_flags(insp_flags), .insp_chan(insp_chan));

    bd_occ_counter #(.MAXV(DEPTH), .OCC_W(OCC_W)) u_occ (
        .clk(clk), .rst(rst), .inc(occ_inc), .dec(occ_dec), .count_q(occ_count));

    assign insp_ready   = insp_flags.ready;
    assign insp_partial = insp_flags.partial;

    assert_busy_leaves_count_R6: assert property (@(posedge clk) disable iff (rst)
        irq_busy |-> occ_count == $past(occ_count) || $past(occ_dec));

endmodule

// File: tb/bd_switch_ring_bench.sv
module bd_switch_ring_bench;
    localparam int DEPTH = 4;
    localparam int CW    = 3;
    localparam int RW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    rx_op = 3'd0;
    logic [CW-1:0] rx_chan = '0;
    logic          tx_req = 1'b0;
    logic          to_en = 1'b0;
    logic [RW-1:0] to_limit = '0;
    logic          tx_valid, tx_skip, tx_free, irq_busy;
    logic [1:0]    tx_idx, insp_idx;
    logic [2:0]    occ_count;
    logic          insp_ready, insp_partial;
    logic [CW-1:0] insp_chan;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bd_switch_ring #(.DEPTH(DEPTH), .CHAN_W(CW), .RETRY_W(RW)) u_bd_switch_ring (
        .clk(clk), .rst(rst), .rx_op(rx_op), .rx_chan(rx_chan), .tx_req(tx_req),
        .to_en(to_en), .to_limit(to_limit), .tx_valid(tx_valid), .tx_skip(tx_skip),
        .tx_free(tx_free), .tx_idx(tx_idx), .irq_busy(irq_busy), .occ_count(occ_count),
        .insp_idx(insp_idx), .insp_ready(insp_ready), .insp_partial(insp_partial),
        .insp_chan(insp_chan));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input int ch, input logic req);
        rx_op = op; rx_chan = CW'(ch); tx_req = req;
        @(negedge clk);
        rx_op = 3'd0; rx_chan = '0; tx_req = 1'b0;
    endtask

    task automatic peek(input string req, input int idx, input int rdy, input int part, input int ch);
        insp_idx = 2'(idx);
        #1;
        chk({req, " ready"}, insp_ready, rdy);
        chk({req, " partial"}, insp_partial, part);
        chk({req, " chan"}, insp_chan, ch);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        for (int i = 0; i < DEPTH; i++) peek("R1", i, 0, 0, 0);
        chk("R1 occ", occ_count, 0);
        chk("R1 outputs", {tx_valid, tx_skip, tx_free, irq_busy}, 0);

        // R2 R3 R7: fill n descriptors then drain
        for (int n = 1; n <= DEPTH; n++) begin
            do_reset();
            for (int k = 0; k < n; k++) begin
                step(3'd1, k + 1, 1'b0);
                peek("R2", k, 0, 1, k + 1);
                step(3'd2, 0, 1'b0);
                peek("R3", k, 1, 0, k + 1);
                chk("R3 occ", occ_count, k + 1);
            end
            if (n == DEPTH) begin
                step(3'd1, 5, 1'b0);
                chk("R6 full no irq", irq_busy, 0);
                peek("R6 full ignored", 0, 1, 0, 1);
            end
            for (int k = 0; k < n; k++) begin
                step(3'd0, 0, 1'b1);
                chk("R7 valid", tx_valid, 1);
                chk("R7 idx", tx_idx, k);
                chk("R7 occ", occ_count, n - k - 1);
                peek("R7 clean", k, 0, 0, 0);
            end
            step(3'd0, 0, 1'b1);
            chk("R9 empty ring", {tx_valid, tx_skip, tx_free}, 0);
        end

        // R4 R8 error then skip
        do_reset();
        step(3'd1, 5, 1'b0);
        step(3'd3, 0, 1'b0);
        peek("R4", 0, 1, 1, 5);
        chk("R4 occ", occ_count, 0);
        step(3'd0, 0, 1'b1);
        chk("R8 skip", tx_skip, 1);
        chk("R8 no valid", tx_valid, 0);
        peek("R8 clean", 0, 0, 0, 0);
        step(3'd1, 2, 1'b0);
        step(3'd2, 0, 1'b0);
        step(3'd0, 0, 1'b1);
        chk("R8 next valid", tx_valid, 1);
        chk("R8 next idx", tx_idx, 1);

        // R5 R6 R9 abort, stuck, busy on wrap
        do_reset();
        to_en = 1'b0; to_limit = 3'd1;
        step(3'd1, 6, 1'b0);
        step(3'd4, 0, 1'b0);
        peek("R5", 0, 0, 1, 6);
        chk("R5 occ", occ_count, 0);
        for (int a = 0; a < 3; a++) begin
            step(3'd0, 0, 1'b1);
            chk("R9 disabled", {tx_valid, tx_skip, tx_free}, 0);
        end
        peek("R9 unchanged", 0, 0, 1, 6);
        for (int k = 1; k < DEPTH; k++) begin
            step(3'd1, k, 1'b0);
            step(3'd2, 0, 1'b0);
        end
        chk("R12 occ", occ_count, 3);
        step(3'd1, 1, 1'b0);
        chk("R6 busy", irq_busy, 1);
        peek("R6 untouched", 0, 0, 1, 6);
        step(3'd0, 0, 1'b0);
        chk("R6 pulse", irq_busy, 0);

        // R10 R11 timeout sweep, limit 0 acts as 1
        for (int lim = 0; lim <= 4; lim++) begin
            int eff;
            eff = (lim == 0) ? 1 : lim;
            do_reset();
            to_en = 1'b1; to_limit = RW'(lim);
            step(3'd1, 3, 1'b0);
            step(3'd4, 0, 1'b0);
            for (int a = 1; a < eff; a++) begin
                step(3'd0, 0, 1'b1);
                chk("R10 early", tx_free, 0);
            end
            step(3'd0, 0, 1'b1);
            chk("R10 free", tx_free, 1);
            chk("R10 idx", tx_idx, 0);
            peek("R10 cleared", 0, 0, 0, 0);
            step(3'd1, 4, 1'b0);
            step(3'd4, 0, 1'b0);
            for (int a = 1; a < eff; a++) begin
                step(3'd0, 0, 1'b1);
                chk("R11 restart", tx_free, 0);
            end
            step(3'd0, 0, 1'b1);
            chk("R11 free", tx_free, 1);
            chk("R11 idx", tx_idx, 1);
        end

        // R9 descriptor being filled is not counted
        do_reset();
        to_en = 1'b1; to_limit = 3'd1;
        step(3'd1, 4, 1'b0);
        step(3'd0, 0, 1'b1);
        step(3'd0, 0, 1'b1);
        chk("R9 filling", tx_free, 0);
        peek("R9 filling kept", 0, 0, 1, 4);
        step(3'd2, 0, 1'b0);
        step(3'd0, 0, 1'b1);
        chk("R9 then sent", tx_valid, 1);

        // R12 done and send together
        do_reset();
        step(3'd1, 1, 1'b0);
        step(3'd2, 0, 1'b0);
        step(3'd1, 2, 1'b0);
        step(3'd2, 0, 1'b1);
        chk("R12 same cycle occ", occ_count, 1);
        chk("R12 valid", tx_valid, 1);
        peek("R12 second ready", 1, 1, 0, 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule